// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-stage register (width set by a parameter) that, on each rising clock edge, does one of four things picked by two select inputs: keep its value, move every bit one place toward the top, move every bit one place toward the bottom, or capture a word from its parallel port. An active-low clear empties the register at once, without waiting for a clock edge.

The parallel port is a single bidirectional tri-state bus. The register drives its contents onto the bus only when both active-low enables are low and load is not selected. In load mode the block releases the bus by itself, so an external source can put the word to be captured on the same wires. The lowest and highest stages also drive two serial taps that are always active. A register's top tap can feed the bottom serial input of the next register, and that register's bottom tap can feed back the other way, so several blocks form one longer shift chain.

The four operations act as the states of the block: HOLD (select 00), SHIFT_UP (01), SHIFT_DOWN (10) and LOAD (11), written as {sel_hi, sel_lo}. Any state can follow any other on the next edge, and the clear forces the register to zero from any state.

Top module: `ushift_bus_reg`

## Requirements
- R1: With {sel_hi, sel_lo} = 11 (LOAD), a rising edge copies bus line n into stage n.
- R2: With {sel_hi, sel_lo} = 01 (SHIFT_UP), a rising edge puts ser_right_in into stage 0 and moves stage n into stage n+1.
- R3: With {sel_hi, sel_lo} = 10 (SHIFT_DOWN), a rising edge puts ser_left_in into the top stage and moves stage n into stage n-1.
- R4: With {sel_hi, sel_lo} = 00 (HOLD), clock edges leave the register unchanged, whatever the serial inputs are doing.
- R5: rst_n low sets every stage to 0 at once, with no clock edge needed, and it overrides the clock and the selects.
- R6: When oe_a_n and oe_b_n are both low and LOAD is not selected, the bus carries the register contents, with bit n on line n.
- R7: If oe_a_n or oe_b_n is high, the block releases the bus (high impedance).
- R8: In LOAD the block releases the bus even when both enables are low.
- R9: A released bus does not stop the register: shifts, loads, holds and clears still take effect while it is released.
- R10: tap_lsb always equals stage 0 and tap_msb always equals the top stage, whatever the enables are set to.
- R11: Two blocks chained top tap to next block's ser_right_in, and that block's bottom tap back to the first block's ser_left_in, shift as one 16-bit register in both directions.
- R12: The first rising edge after rst_n goes high performs the operation selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel_hi | input | 1 | Upper operation select bit |
| sel_lo | input | 1 | Lower operation select bit |
| oe_a_n | input | 1 | Active-low bus enable, first of two |
| oe_b_n | input | 1 | Active-low bus enable, second of two |
| ser_right_in | input | 1 | Serial bit taken into stage 0 during SHIFT_UP |
| ser_left_in | input | 1 | Serial bit taken into the top stage during SHIFT_DOWN |
| pbus | inout | WIDTH | Shared parallel bus: register output or load data |
| tap_lsb | output | 1 | Stage 0, always driven |
| tap_msb | output | 1 | Top stage, always driven |

## Verification
A register result (load, either shift, hold, or the first operation after clear) shows on the bus and taps one rising edge after its select and serial or bus inputs are applied. The bench sets inputs one nanosecond after an edge and reads results one or two nanoseconds after the following edge. Bus release and bus drive follow the enables and selects in the same cycle with no edge between, and the clear takes effect as soon as it is applied. For these the bench changes the control mid-cycle and reads the bus before any clock edge can occur. Pull-ups on the bench bus make a released bus read as all ones, and the bench chooses register values so that all ones cannot be mistaken for a driven value.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Operation codes as {sel_hi, sel_lo}
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_SHIFT_UP   = 2'b01,
        OP_SHIFT_DOWN = 2'b10,
        OP_LOAD  = 2'b11
    } usr_op_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic    sel_hi,
    input  logic    sel_lo,
    output usr_op_e op,
    output logic    load_sel
);

    always_comb begin
        unique case ({sel_hi, sel_lo})
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_SHIFT_UP;
            2'b10:   op = OP_SHIFT_DOWN;
            default: op = OP_LOAD;
        endcase
    end

    assign load_sel = (op == OP_LOAD);

endmodule

// File: rtl/usr_stage_bank.sv
module usr_stage_bank
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  usr_op_e          op,
    input  logic             up_in,
    input  logic             down_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] stage_d;

    // Per-stage next-value selection; end stages take the serial inputs
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_bot
            assign from_below = up_in;
        end else begin : g_mid_b
            assign from_below = stage_q[i-1];
        end

        if (i == TOP) begin : g_top
            assign from_above = down_in;
        end else begin : g_mid_a
            assign from_above = stage_q[i+1];
        end

        always_comb begin
            unique case (op)
                OP_HOLD:       stage_d[i] = stage_q[i];
                OP_SHIFT_UP:   stage_d[i] = from_below;
                OP_SHIFT_DOWN: stage_d[i] = from_above;
                OP_LOAD:       stage_d[i] = par_in[i];
            endcase
        end
    end

    // State register with asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    // ---------------- assertions ----------------
    assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (stage_q == $past(par_in)));

    assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT_UP) |=> (stage_q == {$past(stage_q[TOP-1:0]), $past(up_in)}));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT_DOWN) |=> (stage_q == {$past(down_in), $past(stage_q[TOP:1])}));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(stage_q));

    assert_clear_zero_R5: assert property (@(posedge clk)
        (!rst_n) |-> (stage_q == '0));

endmodule

// File: rtl/usr_bus_ctrl.sv
module usr_bus_ctrl (
    input  logic oe_a_n,
    input  logic oe_b_n,
    input  logic load_sel,
    output logic bus_en
);

    // Drive only when both enables are asserted and load is not selected
    always_comb begin
        bus_en = 1'b0;
        if (!oe_a_n && !oe_b_n) bus_en = !load_sel;
    end

endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_hi,
    input  logic             sel_lo,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    inout  wire  [WIDTH-1:0] pbus,
    output logic             tap_lsb,
    output logic             tap_msb
);

    localparam int TOP = WIDTH - 1;

    usr_op_e          op;
    logic             load_sel;
    logic             bus_en;
    logic [WIDTH-1:0] stage_q;

    usr_mode_decode u_decode (
        .sel_hi   (sel_hi),
        .sel_lo   (sel_lo),
        .op       (op),
        .load_sel (load_sel)
    );

    usr_stage_bank #(.WIDTH(WIDTH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .up_in   (ser_right_in),
        .down_in (ser_left_in),
        .par_in  (pbus),
        .stage_q (stage_q)
    );

    usr_bus_ctrl u_bus (
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .load_sel (load_sel),
        .bus_en   (bus_en)
    );

    assign pbus    = bus_en ? stage_q : {WIDTH{1'bz}};
    assign tap_lsb = stage_q[0];
    assign tap_msb = stage_q[TOP];

    // Driven bus must mirror the register when enabled outside load
    assert_bus_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && !(sel_hi && sel_lo)) |-> (pbus == stage_q));

endmodule

// File: tb/ushift_bus_reg_tb.sv
module ushift_bus_reg_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic s_hi = 0, s_lo = 0, oea = 0, oeb = 0, sr = 0, sl = 0;
    logic tb_drv = 0;
    logic [7:0] tb_data = 8'h00;
    wire  [7:0] bus_a;
    wire  t_lsb, t_msb;

    assign bus_a = tb_drv ? tb_data : 8'hzz;
    for (genvar g = 0; g < 8; g++) begin : g_pu
        pullup (bus_a[g]);
    end

    ushift_bus_reg #(.WIDTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_hi(s_hi), .sel_lo(s_lo),
        .oe_a_n(oea), .oe_b_n(oeb), .ser_right_in(sr), .ser_left_in(sl),
        .pbus(bus_a), .tap_lsb(t_lsb), .tap_msb(t_msb));

    // 16-bit chain
    logic c_hi = 0, c_lo = 0, c_sr = 0, c_sl = 0;
    wire [7:0] lo_bus, hi_bus;
    wire lo_lsb, lo_msb, hi_lsb, hi_msb;

    ushift_bus_reg #(.WIDTH(8)) u_lo (
        .clk(clk), .rst_n(rst_n), .sel_hi(c_hi), .sel_lo(c_lo),
        .oe_a_n(1'b0), .oe_b_n(1'b0), .ser_right_in(c_sr), .ser_left_in(hi_lsb),
        .pbus(lo_bus), .tap_lsb(lo_lsb), .tap_msb(lo_msb));

    ushift_bus_reg #(.WIDTH(8)) u_hi (
        .clk(clk), .rst_n(rst_n), .sel_hi(c_hi), .sel_lo(c_lo),
        .oe_a_n(1'b0), .oe_b_n(1'b0), .ser_right_in(lo_msb), .ser_left_in(c_sl),
        .pbus(hi_bus), .tap_lsb(hi_lsb), .tap_msb(hi_msb));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    // Vector: {mode[1:0], sr, sl, data[7:0], expect[7:0]}; mode = {sel_hi, sel_lo}
    localparam logic [19:0] VEC [10] = '{
        {2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R1 load
        {2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},  // R2 shift up
        {2'b10, 1'b0, 1'b0, 8'h00, 8'h25},  // R3 shift down
        {2'b00, 1'b1, 1'b1, 8'h00, 8'h25},  // R4 hold
        {2'b10, 1'b0, 1'b1, 8'h00, 8'h92},  // R3
        {2'b01, 1'b0, 1'b1, 8'h00, 8'h24},  // R2
        {2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},  // R1
        {2'b01, 1'b1, 1'b0, 8'h00, 8'h79},  // R2
        {2'b01, 1'b1, 1'b0, 8'h00, 8'hF3},  // R2
        {2'b10, 1'b0, 1'b0, 8'h00, 8'h79}   // R3
    };

    logic done = 0;
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] ref16;
        // R5: reset state
        #12;
        chk("R5 reset bus", {8'h0, bus_a}, 16'h0000);
        chk("R5 reset taps", {14'h0, t_msb, t_lsb}, 16'h0000);

        // R12: first edge after release performs shift-up
        @(posedge clk); #1;
        s_hi = 0; s_lo = 1; sr = 1;
        rst_n = 1;
        edge1();
        chk("R12 first op", {8'h0, bus_a}, 16'h0001);
        s_lo = 0; sr = 0;

        // R11: chained shifting both directions
        ref16 = 16'h0000;
        c_hi = 0; c_lo = 1;
        for (int k = 0; k < 16; k++) begin
            c_sr = 1'((16'hB3C5 >> k) & 1);
            ref16 = {ref16[14:0], c_sr};
            edge1();
            chk("R11 chain up", {hi_bus, lo_bus}, ref16);
        end
        c_hi = 1; c_lo = 0;
        for (int k = 0; k < 16; k++) begin
            c_sl = 1'((16'h6E19 >> k) & 1);
            ref16 = {c_sl, ref16[15:1]};
            edge1();
            chk("R11 chain down", {hi_bus, lo_bus}, ref16);
        end
        c_hi = 0; c_lo = 0;

        // Table walk: R1..R4
        for (int v = 0; v < 10; v++) begin
            {s_hi, s_lo} = VEC[v][19:18];
            sr = VEC[v][17]; sl = VEC[v][16];
            tb_data = VEC[v][15:8];
            tb_drv = (VEC[v][19:18] == 2'b11);
            edge1();
            s_hi = 0; s_lo = 0; tb_drv = 0;
            #1;
            chk("R1-4 table", {8'h0, bus_a}, {8'h0, VEC[v][7:0]});
        end

        // R7 / R10: load 0x81, then toggle enables
        s_hi = 1; s_lo = 1; tb_data = 8'h81; tb_drv = 1;
        edge1();
        s_hi = 0; s_lo = 0; tb_drv = 0;
        oea = 1; #1;
        chk("R7 oe_a high released", {8'h0, bus_a}, 16'h00FF);
        chk("R10 taps with bus off", {14'h0, t_msb, t_lsb}, 16'h0003);
        oea = 0; oeb = 1; #1;
        chk("R7 oe_b high released", {8'h0, bus_a}, 16'h00FF);
        oeb = 0; #1;
        chk("R6 driven", {8'h0, bus_a}, 16'h0081);

        // R9: shift while released
        oea = 1; s_lo = 1; sr = 0;
        edge1(); edge1();
        s_lo = 0; oea = 0; #1;
        chk("R9 shifted while released", {8'h0, bus_a}, 16'h0004);

        // R8: load mode releases bus with enables low
        s_hi = 1; s_lo = 1; #1;
        chk("R8 released in load", {8'h0, bus_a}, 16'h00FF);
        edge1();
        s_hi = 0; s_lo = 0; #1;
        chk("R8 loaded pulled-up bus", {8'h0, bus_a}, 16'h00FF);

        // R4: hold across edges with toggling serial inputs
        s_hi = 1; s_lo = 1; tb_data = 8'h6C; tb_drv = 1;
        edge1();
        s_hi = 0; s_lo = 0; tb_drv = 0;
        for (int k = 0; k < 3; k++) begin
            sr = ~sr; sl = ~sl;
            edge1();
        end
        chk("R4 hold", {8'h0, bus_a}, 16'h006C);

        // R5: asynchronous clear mid-cycle
        #1 rst_n = 0; #1;
        chk("R5 async clear", {8'h0, bus_a}, 16'h0000);
        chk("R5 taps cleared", {14'h0, t_msb, t_lsb}, 16'h0000);
        s_hi = 1; s_lo = 1; tb_data = 8'hFF; tb_drv = 1;
        edge1();
        tb_drv = 0; s_hi = 0; s_lo = 0; #1;
        chk("R5 clear overrides load", {8'h0, bus_a}, 16'h0000);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule